// File: doc/BRIEF.md
# E1 Receive Alarm Latched Status

This block watches an E1 receive stream for two alarm conditions and records each change of either condition in an 8-bit sticky status register. The first condition is the far-end multiframe alarm, carried by one bit of timeslot 16 in frame 0 of each signaling multiframe. The second condition is loss of the recovered receive clock, measured in system clocks.

Both conditions are also driven out as live levels. The upstream framer presents one timeslot at a time, with a one-cycle valid strobe and the slot number and frame-within-multiframe number beside it. Software reads the latched register and clears bits by writing ones to them. An interrupt request is raised whenever a latched bit is set and its enable bit is also set.

Top module: `e1_rx_alarm_status`

## Requirements
- R1: `dist_mf_alarm` goes to 1 when the alarm bit has been 1 in two consecutive multiframe samples. A sample is a cycle with `ts_valid`=1, `ts_slot`=16 and `mf_frame`=0. The alarm bit is `ts_data[2]`, which is bit 6 when the slot bits are numbered 1..8 from the MSB. The output changes one clock after the second sample.
- R2: `dist_mf_alarm` returns to 0 one clock after any multiframe sample whose alarm bit is 0.
- R3: Neither `ccs_mode` nor slots with other slot numbers or frame numbers affect the alarm or its two-sample history.
- R4: `rx_clk_lost` goes to 1 once the synchronized receive clock has shown no transition for 8*CLK_PER_BIT system clocks. It returns to 0 shortly after the next transition.
- R5: Detect bits are set on rising edges. Bit 0 is set when the multiframe alarm rises, and bit 3 is set when clock loss rises.
- R6: Clear bits are set on falling edges. Bit 4 is set when the multiframe alarm falls, and bit 7 is set when clock loss falls.
- R7: All latched bits reset to 0 and stay set once set. Bits 6, 5, 2 and 1 always read 0.
- R8: A cycle with `stat_wr`=1 clears every latched bit whose `stat_wdata` bit is 1. If a new edge arrives in the same cycle as the clear, the bit stays set.
- R9: `irq` is the OR of `stat_q & irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_clk | input | 1 | Recovered receive clock, asynchronous |
| ts_valid | input | 1 | One-cycle strobe for a timeslot byte |
| ts_slot | input | 5 | Timeslot number 0..31 |
| mf_frame | input | 4 | Frame number within the multiframe 0..15 |
| ts_data | input | 8 | Timeslot byte |
| ccs_mode | input | 1 | Common-channel signaling mode flag |
| stat_wr | input | 1 | Write strobe for write-one-to-clear |
| stat_wdata | input | 8 | Bits to clear |
| irq_en | input | 8 | Per-bit interrupt enable |
| dist_mf_alarm | output | 1 | Live multiframe alarm |
| rx_clk_lost | output | 1 | Live loss-of-receive-clock |
| stat_q | output | 8 | Latched status register |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `ts_valid` is a single-cycle strobe and that the upstream framer presents slot 16 of frame 0 once per multiframe. They also assume that the receive clock changes slowly enough for the two-flop synchronizer to see every level. The stimulus pulses `ts_valid` for one cycle each time, and it runs the receive clock with a half period of two system clocks. It also interleaves other slots and frames, and toggles `ccs_mode`, between the multiframe samples. Loss of clock is produced by freezing the receive clock. Its state is then checked both before and after the loss window has run out.

// File: rtl/e1_rx_alarm_status.sv
module e1_rx_alarm_status #(
  parameter int CLK_PER_BIT = 4,
  parameter int LOS_BITS    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_clk,
  input  logic       ts_valid,
  input  logic [4:0] ts_slot,
  input  logic [3:0] mf_frame,
  input  logic [7:0] ts_data,
  input  logic       ccs_mode,
  input  logic       stat_wr,
  input  logic [7:0] stat_wdata,
  input  logic [7:0] irq_en,
  output logic       dist_mf_alarm,
  output logic       rx_clk_lost,
  output logic [7:0] stat_q,
  output logic       irq
);

  localparam int LIMIT = LOS_BITS * CLK_PER_BIT;
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);
  localparam logic [7:0] LIVE = 8'b1001_1001;

  logic mf_hit, mf_bit, seen_one;
  logic unused_bits;

  assign mf_hit = ts_valid && (ts_slot == 5'd16) && (mf_frame == 4'd0);
  assign mf_bit = ts_data[2];
  assign unused_bits = ^{ts_data[7:3], ts_data[1:0], ccs_mode};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_one      <= 1'b0;
      dist_mf_alarm <= 1'b0;
    end else if (mf_hit) begin
      seen_one      <= mf_bit;
      dist_mf_alarm <= mf_bit && seen_one;
    end
  end

  logic [2:0] rx_sync;
  logic rx_edge;
  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) rx_sync <= '0;
    else        rx_sync <= {rx_sync[1:0], rx_clk};
  end

  assign rx_edge = rx_sync[2] ^ rx_sync[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt    <= '0;
      rx_clk_lost <= 1'b0;
    end else if (rx_edge) begin
      idle_cnt    <= '0;
      rx_clk_lost <= 1'b0;
    end else if (idle_cnt == LIMIT_C) begin
      rx_clk_lost <= 1'b1;
    end else begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  logic mfa_d, los_d;
  logic [7:0] set_v, clr_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mfa_d <= 1'b0;
      los_d <= 1'b0;
    end else begin
      mfa_d <= dist_mf_alarm;
      los_d <= rx_clk_lost;
    end
  end

  assign set_v = {los_d & ~rx_clk_lost, 2'b00, mfa_d & ~dist_mf_alarm,
                  rx_clk_lost & ~los_d, 2'b00, dist_mf_alarm & ~mfa_d};
  assign clr_v = stat_wr ? stat_wdata : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= 8'h00;
    else        stat_q <= ((stat_q & ~clr_v) | set_v) & LIVE;
  end

  assign irq = |(stat_q & irq_en);

  a_r1_two_samples: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dist_mf_alarm) |-> $past(mf_hit && mf_bit));

  a_r2_zero_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_hit && !mf_bit) |=> !dist_mf_alarm);

  a_r3_ccs_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (!mf_hit && !$stable(ccs_mode)) |=> $stable(dist_mf_alarm));

  a_r4_lost_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_clk_lost) |-> $past(!rx_edge));

  a_r5_rise_latched: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dist_mf_alarm) |=> stat_q[0]);

  a_r6_fall_latched: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_clk_lost) |=> stat_q[7]);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stat_wr) |-> ((stat_q & $past(stat_q)) == $past(stat_q)));

  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q != 8'h00));

endmodule

// File: tb/sim_e1_rx_alarm_status.sv
module sim_e1_rx_alarm_status;
  logic clk = 1'b0, rst_n = 1'b0, rx_clk = 1'b0, rx_run = 1'b1;
  logic ts_valid = 1'b0, ccs_mode = 1'b0, stat_wr = 1'b0;
  logic [4:0] ts_slot = '0;
  logic [3:0] mf_frame = '0;
  logic [7:0] ts_data = '0, stat_wdata = '0, irq_en = '0;
  logic dist_mf_alarm, rx_clk_lost, irq;
  logic [7:0] stat_q;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [7:0] q_st[$];
  logic [2:0] q_fl[$];
  string q_tag[$];

  e1_rx_alarm_status u0 (
    .clk(clk), .rst_n(rst_n), .rx_clk(rx_clk), .ts_valid(ts_valid),
    .ts_slot(ts_slot), .mf_frame(mf_frame), .ts_data(ts_data),
    .ccs_mode(ccs_mode), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .irq_en(irq_en), .dist_mf_alarm(dist_mf_alarm), .rx_clk_lost(rx_clk_lost),
    .stat_q(stat_q), .irq(irq)
  );

  always #2 clk = ~clk;
  initial forever begin
    #8;
    if (rx_run) rx_clk = ~rx_clk;
  end

  always @(negedge clk) begin
    if (q_st.size() > 0) begin
      logic [7:0] est;
      logic [2:0] efl;
      string tag;
      est = q_st.pop_front();
      efl = q_fl.pop_front();
      tag = q_tag.pop_front();
      checks++;
      if (stat_q !== est || {dist_mf_alarm, rx_clk_lost, irq} !== efl) begin
        errors++;
        $display("FAIL %s: got st=%h mfa/lost/irq=%b expected st=%h mfa/lost/irq=%b",
                 tag, stat_q, {dist_mf_alarm, rx_clk_lost, irq}, est, efl);
      end
    end
  end

  task automatic chk(input logic [7:0] st, input logic mfa, input logic lost,
                     input logic ir, input string tag);
    @(posedge clk); #1;
    q_st.push_back(st);
    q_fl.push_back({mfa, lost, ir});
    q_tag.push_back(tag);
    @(negedge clk); #1;
  endtask

  task automatic send_ts(input logic [4:0] s, input logic [3:0] f, input logic b);
    @(negedge clk);
    ts_valid = 1'b1; ts_slot = s; mf_frame = f; ts_data = {5'b10101, b, 2'b10};
    @(negedge clk);
    ts_valid = 1'b0; ts_data = 8'h00;
  endtask

  task automatic w1c(input logic [7:0] m);
    @(negedge clk); stat_wr = 1'b1; stat_wdata = m;
    @(negedge clk); stat_wr = 1'b0; stat_wdata = 8'h00;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    chk(8'h00, 0, 0, 0, "R7 reset state");

    send_ts(5'd16, 4'd0, 1'b1);
    chk(8'h00, 0, 0, 0, "R1 one sample not enough");
    ccs_mode = 1'b1;
    send_ts(5'd16, 4'd3, 1'b0);
    send_ts(5'd5, 4'd0, 1'b0);
    chk(8'h00, 0, 0, 0, "R3 other slot/frame ignored");
    send_ts(5'd16, 4'd0, 1'b1);
    chk(8'h01, 1, 0, 0, "R1 R5 alarm after two samples in ccs mode");
    ccs_mode = 1'b0;
    chk(8'h01, 1, 0, 0, "R3 ccs toggle no effect");
    irq_en = 8'h01;
    chk(8'h01, 1, 0, 1, "R9 irq enabled");
    w1c(8'h01);
    chk(8'h00, 1, 0, 0, "R8 write-one-to-clear");

    send_ts(5'd16, 4'd0, 1'b0);
    chk(8'h10, 0, 0, 0, "R2 R6 alarm falls, clear bit latched");
    irq_en = 8'h10;
    chk(8'h10, 0, 0, 1, "R9 irq on bit 4");
    w1c(8'h10);
    chk(8'h00, 0, 0, 0, "R8 clear bit 4");

    send_ts(5'd16, 4'd0, 1'b1);
    chk(8'h00, 0, 0, 0, "R1 first of new pair");
    @(negedge clk);
    ts_valid = 1'b1; ts_slot = 5'd16; mf_frame = 4'd0; ts_data = 8'h04;
    @(negedge clk);
    ts_valid = 1'b0; ts_data = 8'h00; stat_wr = 1'b1; stat_wdata = 8'h01;
    @(negedge clk);
    stat_wr = 1'b0; stat_wdata = 8'h00;
    chk(8'h01, 1, 0, 0, "R8 edge wins over clear");
    w1c(8'h01);
    w1c(8'hFF);
    irq_en = 8'hFF;
    chk(8'h00, 1, 0, 0, "R7 unused bits read 0");

    rx_run = 1'b0;
    repeat (20) @(posedge clk);
    chk(8'h00, 1, 0, 0, "R4 not lost before window");
    repeat (30) @(posedge clk);
    chk(8'h08, 1, 1, 1, "R4 R5 clock lost");
    rx_run = 1'b1;
    repeat (10) @(posedge clk);
    chk(8'h88, 1, 0, 1, "R4 R6 clock back, sticky detect kept R7");
    w1c(8'h88);
    chk(8'h00, 1, 0, 0, "R8 R9 clear both");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule